// File: doc/BRIEF.md
# Automatic CHR-RAM Half-Table Switch

This block drives line A12 of an 8 KiB unbanked CHR-RAM so that the picture can use a different pattern table above and below the middle of the screen, whatever the scroll position. It watches the PPU address bus. When PPU A13 goes from low to high during a PPU access, that access is a nametable fetch, and the block stores PPU A9 at that moment. A9 tells whether the fetched nametable row lies in the top half or the bottom half of its nametable. Pattern fetches that follow (A13 low) then take their A12 from the stored bit. The top half of each nametable therefore draws from the left table and the bottom half from the right table.

A single control bit turns the automatic switch on or off. It is bit 7 of a CPU register. The register responds to any write whose address matches a base value under a mask (by default base 0x5000, mask 0xFF00). When the switch is off, and whenever PPU A13 is high, CHR A12 is simply PPU A12. All state resets to zero, so the block starts in pass-through mode.

Top module: `chr_half_switch`

## Requirements
- R1: After reset the enable bit and the stored half bit are both 0, so chr_a12 equals ppu_a12.
- R2: A CPU write whose address ANDed with 0xFF00 equals 0x5000 (for example 0x5000 or 0x50FF) loads the enable bit from cpu_wd_en (data bit 7). The new value governs chr_a12 from the cycle after the write.
- R3: A CPU write to any other address (for example 0x5100 or 0x4000) leaves the enable bit unchanged.
- R4: While the enable bit is 0, chr_a12 equals ppu_a12 in the same cycle.
- R5: While the enable bit is 1 and ppu_a13 is 0, chr_a12 equals the stored half bit.
- R6: In a cycle where ppu_a13 is 1, its sample from the previous cycle was 0, and ppu_acc is 1, the stored half bit takes ppu_a9. The new value is visible from the next cycle.
- R7: A rising edge of ppu_a13 while ppu_acc is 0 leaves the stored half bit unchanged.
- R8: While ppu_a13 stays high, with no new rising edge, changes on ppu_a9 leave the stored half bit unchanged, even when ppu_acc is 1.
- R9: While ppu_a13 is 1, chr_a12 equals ppu_a12 whatever the enable bit is.
- R10: A write that clears the enable bit in the middle of a frame returns chr_a12 to ppu_a12 from the very next cycle.
- R11: The stored half bit keeps its value while the enable bit is 0, and is used again as soon as the enable bit returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr | input | 1 | CPU register write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU address of the write |
| cpu_wd_en | input | 1 | Data bit 7 of the CPU write (the enable value) |
| ppu_a13 | input | 1 | PPU address line 13 (high for nametable space) |
| ppu_a12 | input | 1 | PPU address line 12 |
| ppu_a9 | input | 1 | PPU address line 9 (nametable row half) |
| ppu_acc | input | 1 | PPU read or write access in progress |
| chr_a12 | output | 1 | A12 line driven to the CHR-RAM |

## Verification
The assertions assume that the PPU lines and the access strobe are already synchronous to clk, with one stable value per cycle. Edge detection compares each sample only with the one taken on the previous clock. The bench drives every input on the falling edge and holds it for a full cycle. It keeps ppu_a13 low through reset, so the first edge after reset is a real one. Each rising edge of A13 that the bench creates is preceded by at least one cycle with A13 low.

// File: rtl/chr_sw_pkg.sv
// Package: shared defaults and helpers for the CHR half-table switch.
// Assumes a 16-bit CPU address and a register decoded under a mask.
package chr_sw_pkg;

    localparam int unsigned          CPU_ADDR_W   = 16;
    localparam logic [CPU_ADDR_W-1:0] CFG_BASE    = 16'h5000;
    localparam logic [CPU_ADDR_W-1:0] CFG_MASK    = 16'hFF00;

    // Source chosen for the CHR A12 line
    typedef enum logic [1:0] {
        SRC_PPU_A12  = 2'd0,
        SRC_HALF_BIT = 2'd1
    } a12_src_e;

    // Masked address compare used by the register decode
    function automatic logic addr_hit(
        input logic [CPU_ADDR_W-1:0] addr,
        input logic [CPU_ADDR_W-1:0] base,
        input logic [CPU_ADDR_W-1:0] mask
    );
        return ((addr & mask) == (base & mask));
    endfunction

endpackage

// File: rtl/chr_sw_cfg.sv
// Module: chr_sw_cfg
// Holds the automatic-switch enable bit. It is loaded on a CPU write
// whose address matches BASE under MASK. Assumes cpu_wr lasts one cycle
// per write and that the data bit is valid in that cycle.
module chr_sw_cfg
    import chr_sw_pkg::*;
#(
    parameter int unsigned          ADDR_W = CPU_ADDR_W,
    parameter logic [ADDR_W-1:0]    BASE   = CFG_BASE,
    parameter logic [ADDR_W-1:0]    MASK   = CFG_MASK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wd_en,
    output logic              auto_en
);

    logic sel;

    // Decode: this register is addressed by the current write
    always_comb begin
        sel = cpu_wr && ((cpu_addr & MASK) == (BASE & MASK));
    end

    // Enable register: reset clear, loaded on a decoded write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            auto_en <= 1'b0;
        end else if (sel) begin
            auto_en <= cpu_wd_en;
        end
    end

endmodule

// File: rtl/chr_sw_half_latch.sv
// Module: chr_sw_half_latch
// Detects a rising edge of PPU A13 by comparing it with the previous
// clock sample. On an edge that comes with an access strobe it stores
// PPU A9. Assumes the PPU lines are synchronous to clk. The previous
// sample is taken even during reset, so a level already high at release
// does not count as an edge.
module chr_sw_half_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic ppu_a13,
    input  logic ppu_a9,
    input  logic ppu_acc,
    output logic half_sel
);

    logic a13_prev;
    logic a13_rise;

    // Previous-sample register for edge detection (sampled always)
    always_ff @(posedge clk) begin
        a13_prev <= ppu_a13;
    end

    // Edge qualifier: low-to-high transition of A13
    always_comb begin
        a13_rise = ppu_a13 && !a13_prev;
    end

    // Half-select register: capture A9 on a qualified edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_sel <= 1'b0;
        end else if (a13_rise && ppu_acc) begin
            half_sel <= ppu_a9;
        end
    end

endmodule

// File: rtl/chr_sw_mux.sv
// Module: chr_sw_mux
// Chooses the source of the CHR A12 line. The stored half bit is used
// only for pattern space (A13 low) with the switch enabled. Otherwise
// PPU A12 passes through. Purely combinational.
module chr_sw_mux
    import chr_sw_pkg::*;
(
    input  logic auto_en,
    input  logic ppu_a13,
    input  logic ppu_a12,
    input  logic half_sel,
    output logic chr_a12
);

    a12_src_e src;

    // Source selection from the enable and the address space
    always_comb begin
        src = (auto_en && !ppu_a13) ? SRC_HALF_BIT : SRC_PPU_A12;
    end

    // Output drive from the selected source
    always_comb begin
        case (src)
            SRC_HALF_BIT: chr_a12 = half_sel;
            default:      chr_a12 = ppu_a12;
        endcase
    end

endmodule

// File: rtl/chr_half_switch.sv
// Module: chr_half_switch (top)
// Drives CHR-RAM A12. In automatic mode the pattern table follows the
// nametable half last fetched. In pass-through mode PPU A12 goes straight
// to the CHR-RAM. Assumes all inputs are synchronous to clk, and uses a
// synchronous active-low reset.
module chr_half_switch
    import chr_sw_pkg::*;
#(
    parameter int unsigned       ADDR_W   = CPU_ADDR_W,
    parameter logic [ADDR_W-1:0] CFG_ADDR = CFG_BASE,
    parameter logic [ADDR_W-1:0] CFG_MSK  = CFG_MASK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wd_en,
    input  logic              ppu_a13,
    input  logic              ppu_a12,
    input  logic              ppu_a9,
    input  logic              ppu_acc,
    output logic              chr_a12
);

    logic auto_en;
    logic half_sel;

    chr_sw_cfg #(
        .ADDR_W (ADDR_W),
        .BASE   (CFG_ADDR),
        .MASK   (CFG_MSK)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_wr    (cpu_wr),
        .cpu_addr  (cpu_addr),
        .cpu_wd_en (cpu_wd_en),
        .auto_en   (auto_en)
    );

    chr_sw_half_latch u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .ppu_a13  (ppu_a13),
        .ppu_a9   (ppu_a9),
        .ppu_acc  (ppu_acc),
        .half_sel (half_sel)
    );

    chr_sw_mux u_mux (
        .auto_en  (auto_en),
        .ppu_a13  (ppu_a13),
        .ppu_a12  (ppu_a12),
        .half_sel (half_sel),
        .chr_a12  (chr_a12)
    );

endmodule

// File: rtl/chr_half_switch_chk.sv
// Module: chr_half_switch_chk
// Assertion checker bound to chr_half_switch. Assumes inputs are
// synchronous to clk, with one value per cycle.
module chr_half_switch_chk
    import chr_sw_pkg::*;
#(
    parameter int unsigned       ADDR_W   = CPU_ADDR_W,
    parameter logic [ADDR_W-1:0] CFG_ADDR = CFG_BASE,
    parameter logic [ADDR_W-1:0] CFG_MSK  = CFG_MASK
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_wr,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_wd_en,
    input logic              ppu_a13,
    input logic              ppu_a12,
    input logic              ppu_a9,
    input logic              ppu_acc,
    input logic              chr_a12,
    input logic              auto_en,
    input logic              half_sel
);

    logic hit;
    always_comb hit = cpu_wr && ((cpu_addr & CFG_MSK) == (CFG_ADDR & CFG_MSK));

    // R2: a decoded write loads the enable bit
    p_cfg_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (auto_en == $past(cpu_wd_en)));

    // R3: other writes leave the enable bit alone
    p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(auto_en));

    // R4: disabled means pass-through
    p_pass_dis_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en |-> (chr_a12 == ppu_a12));

    // R9: nametable space always passes A12 through
    p_pass_nt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ppu_a13 |-> (chr_a12 == ppu_a12));

    // R6: a qualified rising edge captures A9
    p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ppu_a13 && !$past(ppu_a13) && ppu_acc) |=> (half_sel == $past(ppu_a9)));

    // R7 and R8: the stored bit holds without a qualified edge
    p_half_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ppu_a13 && !$past(ppu_a13) && ppu_acc) |=> $stable(half_sel));

endmodule

bind chr_half_switch chr_half_switch_chk #(
    .ADDR_W   (ADDR_W),
    .CFG_ADDR (CFG_ADDR),
    .CFG_MSK  (CFG_MSK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_wr    (cpu_wr),
    .cpu_addr  (cpu_addr),
    .cpu_wd_en (cpu_wd_en),
    .ppu_a13   (ppu_a13),
    .ppu_a12   (ppu_a12),
    .ppu_a9    (ppu_a9),
    .ppu_acc   (ppu_acc),
    .chr_a12   (chr_a12),
    .auto_en   (auto_en),
    .half_sel  (half_sel)
);

// File: tb/chr_half_switch_tb.sv
`timescale 1ns/100ps
// Bench: scoreboard. The driver pushes the expected chr_a12 for each
// cycle, and the monitor pops and compares it mid-cycle.
module chr_half_switch_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic        cpu_wd_en = 1'b0;
    logic        ppu_a13 = 1'b0;
    logic        ppu_a12 = 1'b0;
    logic        ppu_a9 = 1'b0;
    logic        ppu_acc = 1'b0;
    logic        chr_a12;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic  exp_q[$];
    string tag_q[$];

    // reference state from the requirements
    logic m_en = 1'b0;
    logic m_half = 1'b0;
    logic m_prev = 1'b0;

    always #2 clk = ~clk;

    chr_half_switch u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_wr    (cpu_wr),
        .cpu_addr  (cpu_addr),
        .cpu_wd_en (cpu_wd_en),
        .ppu_a13   (ppu_a13),
        .ppu_a12   (ppu_a12),
        .ppu_a9    (ppu_a9),
        .ppu_acc   (ppu_acc),
        .chr_a12   (chr_a12)
    );

    // drive one cycle, push its expected output, advance the model
    task automatic step(input logic wr, input logic [15:0] addr, input logic d7,
                        input logic a13, input logic a12, input logic a9,
                        input logic acc, input string tag);
        @(negedge clk);
        cpu_wr = wr; cpu_addr = addr; cpu_wd_en = d7;
        ppu_a13 = a13; ppu_a12 = a12; ppu_a9 = a9; ppu_acc = acc;
        #0.5;
        exp_q.push_back((m_en && !a13) ? m_half : a12);
        tag_q.push_back(tag);
        if (wr && ((addr & 16'hFF00) == 16'h5000)) m_en = d7;
        if (a13 && !m_prev && acc) m_half = a9;
        m_prev = a13;
    endtask

    task automatic idle(input logic a12, input string tag);
        step(1'b0, 16'h0000, 1'b0, 1'b0, a12, 1'b0, 1'b0, tag);
    endtask

    // monitor: compare mid-cycle, well before the next rising edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                logic  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (chr_a12 !== e) begin
                    fails++;
                    $display("FAIL %s: chr_a12 actual=%b expected=%b", t, chr_a12, e);
                end
            end
        end
    end

    // watchdog
    initial begin
        #20000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 and R4: reset state is pass-through
        idle(1'b0, "R1 reset a12=0");
        idle(1'b1, "R1 reset a12=1");
        idle(1'b0, "R4 disabled a12=0");
        // R11: capture while disabled (R6), output still follows A12
        step(1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R9 nt fetch a9=1 disabled");
        idle(1'b0, "R11 disabled keeps pass-through");
        // R2: enable via 0x5000
        step(1'b1, 16'h5000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R2 write enable cycle");
        idle(1'b0, "R11 stored half reused a12=0");
        idle(1'b1, "R5 stored half a12=1");
        // R9: nametable space passes A12
        step(1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R9 nt space a12=0");
        step(1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R9 nt space a12=1");
        // R7: rising edge with no access strobe
        idle(1'b0, "R5 low gap");
        step(1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R7 edge no strobe");
        idle(1'b0, "R7 half unchanged");
        // R6: qualified edge with a9=0
        step(1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R6 capture a9=0");
        // R8: a13 stays high, a9 changes
        step(1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R8 held high a9=1");
        idle(1'b1, "R6 half now 0");
        // R6: qualified edge with a9=1
        step(1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R6 capture a9=1");
        idle(1'b0, "R6 half now 1");
        // R3: non-matching writes
        step(1'b1, 16'h5100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3 write 0x5100");
        idle(1'b0, "R3 still enabled after 0x5100");
        step(1'b1, 16'h4000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3 write 0x4000");
        idle(1'b0, "R3 still enabled after 0x4000");
        // R10 and R2: clear through the mirror 0x50FF
        step(1'b1, 16'h50FF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 clear write cycle");
        idle(1'b0, "R10 cleared a12=0");
        idle(1'b1, "R10 cleared a12=1");
        // R11: re-enable, the stored bit is reused
        step(1'b1, 16'h5000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R4 write cycle still off");
        idle(1'b0, "R11 re-enabled half=1");
        idle(1'b0, "R5 final");
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule